// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Data Path

This block models the data path of a pipelined synchronous SRAM. The word address, chip select, write controls and write data are captured on the rising clock edge. Read data comes back through one output register, so a read captured on one edge drives the bus after the next edge. A new command can be accepted on every cycle. The word address comes from a separate burst address generator; this block does not step through bursts itself.

Writes are either global, which updates the whole word, or byte-masked, which updates only the selected 9-bit lanes. A mode input picks how the output drivers turn off after a deselect. In single-cycle mode they turn off one cycle earlier than in dual-cycle mode, which keeps the last read word on the bus for one extra cycle. Output enable and sleep act on the drive enable combinationally, without waiting for a clock. While sleep is high, incoming commands are dropped and the stored contents are kept.

The bus is modelled as a data output `dq_out` and a drive enable `dq_en`. When `dq_en` is low the pins are high impedance. When `dq_en` is high, `dq_out` is the value on the pins.

Top module: `syncburst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, and on the cycle after reset is released with only idle commands, `dq_en` is 0.
- R2: A read (`cs_n`=0, `gw_n`=1, `bwe_n`=1) captured at edge E makes `dq_en`=1 after edge E+1, with `dq_out` equal to the stored word at that address.
- R3: Reads presented on consecutive cycles return their words on consecutive cycles, with no idle gap between them.
- R4: A write with `gw_n`=0 updates all four 9-bit lanes of the word, whatever the values of `bwe_n` and `bsel_n`.
- R5: With `gw_n`=1 and `bwe_n`=0, only the lanes whose `bsel_n[i]` is 0 are written. Lane i is bits 9i+8 down to 9i. If every `bsel_n` bit is 1, the word is left unchanged.
- R6: With `gw_n`=1 and `bwe_n`=1 the cycle is a read, so `bsel_n` and `din` cannot change the array.
- R7: A read of an address captured on the edge right after a write to that address returns the newly written word.
- R8: The mode is captured with each command. With `single_dsel`=1, take a read at edge E followed by a deselect (`cs_n`=1) at E+1. The read word is driven after E+1, and `dq_en` is 0 after E+2.
- R9: With `single_dsel`=0, the same sequence keeps `dq_en`=1 with the same `dq_out` after E+2, and `dq_en` is 0 after E+3.
- R10: A write captured directly after a read ends the drive after the next edge, in both modes, with no extra hold cycle.
- R11: `oe_n`=1 forces `dq_en` to 0 at once, without a clock edge. Returning `oe_n` to 0 restores the drive.
- R12: `sleep`=1 forces `dq_en` to 0 at once. Commands captured during sleep, writes included, have no effect, and stored data is kept through sleep.
- R13: A cycle with `cs_n`=1 does not write, even if `gw_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address from the burst address generator |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTES | Per-lane write selects, active low |
| din | input | BYTE_W*NBYTES | Write data |
| single_dsel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Standby request, asynchronous on the drive |
| dq_out | output | BYTE_W*NBYTES | Read data shown on the bus |
| dq_en | output | 1 | Bus drive enable; pins are high impedance when 0 |

## Verification
The bench checks the deselect timing in both modes, cycle by cycle. A design with the mode inverted, or without the extra hold, would end the drive one edge too early or too late. It checks a read-then-write turnaround in dual-cycle mode, where a design that also extends the drive after writes would fight the incoming write data. It checks that a mask with no lanes selected, a byte mask with `bwe_n` high, a write with chip select high and a write during sleep all leave the word untouched. Read-after-write to the same address and back-to-back reads catch a pipeline that returns stale data or inserts a bubble.

// File: rtl/psram_pkg.sv
// Shared types for the pipelined SRAM data path.
// Assumes: one command per cycle; the command kind is all that downstream
// stages need to know about a captured cycle.
package psram_pkg;

    // Kind of cycle held in the input register stage
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/psram_in_stage.sv
// Input register stage: captures the command, address, lane mask, write
// data and deselect mode on each rising edge.
// Assumes: controls are active low; sleep or a high chip select turns the
// cycle into an idle command so nothing downstream acts on it.
module psram_in_stage
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       gw_n,
    input  logic                       bwe_n,
    input  logic [NBYTES-1:0]          bsel_n,
    input  logic [BYTE_W*NBYTES-1:0]   din,
    input  logic                       single_dsel,
    input  logic                       sleep,
    output cmd_e                       s1_cmd,
    output logic [ADDR_W-1:0]          s1_addr,
    output logic [NBYTES-1:0]          s1_mask,
    output logic [BYTE_W*NBYTES-1:0]   s1_din,
    output logic                       s1_single
);

    localparam int WORD_W = BYTE_W * NBYTES;

    logic [NBYTES-1:0] lane_sel;
    logic              is_write;

    // Per-lane write select: global write forces every lane on
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane_sel
        assign lane_sel[g] = !gw_n || (!bwe_n && !bsel_n[g]);
    end

    // A cycle is a write when either write control is asserted
    assign is_write = !gw_n || !bwe_n;

    // Capture the command kind, lane mask and mode, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_cmd    <= CMD_IDLE;
            s1_mask   <= '0;
            s1_single <= 1'b1;
        end else begin
            s1_single <= single_dsel;
            if (cs_n || sleep) begin
                s1_cmd  <= CMD_IDLE;
                s1_mask <= '0;
            end else if (is_write) begin
                s1_cmd  <= CMD_WRITE;
                s1_mask <= lane_sel;
            end else begin
                s1_cmd  <= CMD_READ;
                s1_mask <= '0;
            end
        end
    end

    // Capture address and write data; no reset needed on the data path
    always_ff @(posedge clk) begin
        s1_addr <= addr;
        s1_din  <= din[WORD_W-1:0];
    end

    // Sleep at a capture edge must produce an idle command
    AST_SLEEP_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s1_cmd == CMD_IDLE)); // R12

    // A deselected cycle can never become a write
    AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (s1_cmd != CMD_WRITE)); // R13

endmodule

// File: rtl/psram_array.sv
// Storage array split into independent lanes, one per byte, so a
// masked write touches only its selected lanes.
// Assumes: write is applied at the edge after the command is captured;
// read is combinational from the captured address.
module psram_array #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 4
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [NBYTES-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W*NBYTES-1:0]   wdata,
    output logic [BYTE_W*NBYTES-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];

        // Update this lane when the write selects it
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        // Lane read port driven from the captured address
        assign rdata[g*BYTE_W +: BYTE_W] = mem[addr];
    end

endmodule

// File: rtl/psram_out_stage.sv
// Output register stage and bus drive control. Holds the read word and a
// valid flag; in dual-cycle mode a deselect adds one extra hold cycle.
// Assumes: output enable and sleep are combinational overrides on drive.
module psram_out_stage
    import psram_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic              s1_single,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_en
);

    logic              out_valid;
    logic              hold_ext;
    logic [WORD_W-1:0] out_data;

    // Track read validity and the dual-cycle extension flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hold_ext  <= 1'b0;
        end else begin
            out_valid <= (s1_cmd == CMD_READ);
            hold_ext  <= !s1_single && (s1_cmd == CMD_IDLE) && out_valid;
        end
    end

    // Load the output word only on reads so a held word stays put
    always_ff @(posedge clk) begin
        if (s1_cmd == CMD_READ) begin
            out_data <= rd_data;
        end
    end

    assign dq_out = out_data;
    assign dq_en  = (out_valid || hold_ext) && !oe_n && !sleep;

    // Reset leaves nothing to drive on the following cycle
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !hold_ext)); // R1

    // Every captured read reaches the output register one edge later
    AST_READ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_READ) |=> out_valid); // R2

    // A captured write never leaves the bus driven afterwards
    AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_WRITE) |=> (!out_valid && !hold_ext)); // R10

    // Single-cycle mode never extends the drive after a deselect
    AST_SCD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_single && s1_cmd == CMD_IDLE) |=> !hold_ext); // R8

    // The extended cycle repeats the previous word unchanged
    AST_DCD_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ext |-> $stable(out_data)); // R9

endmodule

// File: rtl/syncburst_sram.sv
// Top of the pipelined synchronous SRAM data path: input register stage,
// lane-split array and output stage with selectable deselect timing.
// Assumes: the word address comes from an external burst generator; the
// bus is shown as data plus a drive enable.
module syncburst_sram
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [NBYTES-1:0]        bsel_n,
    input  logic [BYTE_W*NBYTES-1:0] din,
    input  logic                     single_dsel,
    input  logic                     oe_n,
    input  logic                     sleep,
    output logic [BYTE_W*NBYTES-1:0] dq_out,
    output logic                     dq_en
);

    localparam int WORD_W = BYTE_W * NBYTES;

    cmd_e              s1_cmd;
    logic [ADDR_W-1:0] s1_addr;
    logic [NBYTES-1:0] s1_mask;
    logic [WORD_W-1:0] s1_din;
    logic              s1_single;
    logic [WORD_W-1:0] rd_data;
    logic              wr_en;

    assign wr_en = (s1_cmd == CMD_WRITE);

    psram_in_stage #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .din(din),
        .single_dsel(single_dsel), .sleep(sleep),
        .s1_cmd(s1_cmd), .s1_addr(s1_addr), .s1_mask(s1_mask),
        .s1_din(s1_din), .s1_single(s1_single)
    );

    psram_array #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)
    ) u_array (
        .clk(clk), .wr_en(wr_en), .wr_mask(s1_mask), .addr(s1_addr),
        .wdata(s1_din), .rdata(rd_data)
    );

    psram_out_stage #(
        .WORD_W(WORD_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .s1_cmd(s1_cmd), .s1_single(s1_single),
        .rd_data(rd_data), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_en(dq_en)
    );

endmodule

// File: tb/syncburst_sram_bench.sv
// Directed bench: one task per scenario; inputs change on the falling edge
// and outputs are sampled there, half a cycle after the rising edge.
module syncburst_sram_bench;

    localparam int AW = 6;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          gw_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [3:0]    bsel_n = 4'hF;
    logic [W-1:0]  din = '0;
    logic          single_dsel = 1'b1;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [W-1:0]  dq_out;
    logic          dq_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [W-1:0] WORD_D  = 36'h1_2345_6789;
    localparam logic [W-1:0] WORD_E  = 36'hE_DCBA_9876;
    localparam logic [W-1:0] ALL_ONE = 36'hF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    syncburst_sram u_syncburst_sram (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .din(din),
        .single_dsel(single_dsel), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic op_idle();
        cs_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    endtask

    task automatic op_read(input logic [AW-1:0] a);
        cs_n = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; addr = a;
    endtask

    task automatic op_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                            input logic g, input logic b, input logic [3:0] s);
        cs_n = 1'b0; gw_n = g; bwe_n = b; bsel_n = s; addr = a; din = d;
    endtask

    // Read one word in isolation and check it after the output edge
    task automatic read_expect(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
        op_read(a); tick();
        op_idle();  tick();
        chk(req, {35'd0, dq_en}, 36'd1);
        chk(req, dq_out, exp);
        tick(); tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_idle();
        repeat (3) tick();
        chk("R1 drive in reset", {35'd0, dq_en}, 36'd0);
        rst_n = 1'b1; tick();
        chk("R1 drive after reset", {35'd0, dq_en}, 36'd0);
    endtask

    task automatic t_global_write();
        single_dsel = 1'b1;
        op_write(6'd3, WORD_D, 1'b0, 1'b1, 4'hF); tick();
        op_idle(); tick();
        read_expect("R4 global write ignores bsel_n", 6'd3, WORD_D);
    endtask

    task automatic t_byte_write();
        op_write(6'd5, ALL_ONE, 1'b0, 1'b0, 4'h0); tick();
        op_write(6'd5, 36'd0, 1'b1, 1'b0, 4'b1010); tick();
        op_idle(); tick();
        read_expect("R5 lanes 0 and 2 only", 6'd5, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
        op_write(6'd5, WORD_E, 1'b1, 1'b0, 4'hF); tick();
        op_idle(); tick();
        read_expect("R5 empty mask leaves word", 6'd5, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
    endtask

    task automatic t_no_write_paths();
        op_write(6'd5, WORD_E, 1'b1, 1'b1, 4'h0); tick();
        op_idle(); tick();
        read_expect("R6 bsel_n without enable", 6'd5, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
        op_write(6'd5, WORD_E, 1'b0, 1'b0, 4'h0); cs_n = 1'b1; tick();
        op_idle(); tick();
        read_expect("R13 deselected write", 6'd5, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
    endtask

    task automatic t_read_after_write();
        op_write(6'd7, WORD_E, 1'b0, 1'b1, 4'hF); tick();
        read_expect("R7 read right after write", 6'd7, WORD_E);
    endtask

    task automatic t_burst_reads();
        for (int i = 0; i < 4; i++) begin
            op_write(6'(8 + i), {4'(i), 32'hC0DE_0000 + 32'(i)}, 1'b0, 1'b1, 4'hF);
            tick();
        end
        op_read(6'd8); tick();
        for (int i = 1; i < 5; i++) begin
            if (i < 4) op_read(6'(8 + i)); else op_idle();
            tick();
            chk("R3 back-to-back drive", {35'd0, dq_en}, 36'd1);
            chk("R3 back-to-back data", dq_out, {4'(i - 1), 32'hC0DE_0000 + 32'(i - 1)});
        end
        op_idle(); tick(); tick();
    endtask

    task automatic t_single_deselect();
        single_dsel = 1'b1;
        op_read(6'd3); tick();
        op_idle(); tick();
        chk("R8 read driven", dq_out, WORD_D);
        chk("R8 drive on", {35'd0, dq_en}, 36'd1);
        tick();
        chk("R8 drive off one edge later", {35'd0, dq_en}, 36'd0);
        tick();
    endtask

    task automatic t_dual_deselect();
        single_dsel = 1'b0;
        op_read(6'd7); tick();
        op_idle(); tick();
        chk("R9 drive on", {35'd0, dq_en}, 36'd1);
        tick();
        chk("R9 drive held", {35'd0, dq_en}, 36'd1);
        chk("R9 held word", dq_out, WORD_E);
        tick();
        chk("R9 drive off", {35'd0, dq_en}, 36'd0);
        tick();
    endtask

    task automatic t_write_turnaround();
        single_dsel = 1'b0;
        op_read(6'd3); tick();
        op_write(6'd20, WORD_E, 1'b0, 1'b1, 4'hF); tick();
        chk("R10 read before write", {35'd0, dq_en}, 36'd1);
        op_idle(); tick();
        chk("R10 write ends drive", {35'd0, dq_en}, 36'd0);
        tick();
        chk("R10 no hold after write", {35'd0, dq_en}, 36'd0);
        single_dsel = 1'b1;
    endtask

    task automatic t_output_enable();
        op_read(6'd3); tick(); tick();
        chk("R11 drive before oe", {35'd0, dq_en}, 36'd1);
        oe_n = 1'b1; #1;
        chk("R11 oe_n high", {35'd0, dq_en}, 36'd0);
        oe_n = 1'b0; #1;
        chk("R11 oe_n low again", {35'd0, dq_en}, 36'd1);
    endtask

    task automatic t_sleep();
        sleep = 1'b1; #1;
        chk("R12 sleep stops drive", {35'd0, dq_en}, 36'd0);
        tick();
        op_write(6'd3, WORD_E, 1'b0, 1'b1, 4'hF); tick(); tick();
        chk("R12 no drive in sleep", {35'd0, dq_en}, 36'd0);
        op_idle(); sleep = 1'b0; tick(); tick();
        read_expect("R12 data kept and write dropped", 6'd3, WORD_D);
    endtask

    initial begin
        tick();
        t_reset();
        t_global_write();
        t_byte_write();
        t_no_write_paths();
        t_read_after_write();
        t_burst_reads();
        t_single_deselect();
        t_dual_deselect();
        t_write_turnaround();
        t_output_enable();
        t_sleep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule